// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Front End

This block is an SPI master that moves a single byte per transfer. Software sees three word registers on a small chip-select/write-enable bus: one holding the select level, one whose write launches a transfer (and whose read reports idle), and one that takes the outgoing byte on write and returns the last received byte on read. The select line is not tied to a transfer. It is a sticky level that software raises and lowers through its own register, so a command, its address bytes and any number of data bytes can all run inside one select window.

The serial side uses clock mode 0. The serial clock idles low, the master's output bit moves when the clock falls, and the input line is sampled when it rises, most significant bit first. The serial clock comes from the system clock through a parameterised half-period divider. The outgoing byte is latched into a holding register when written. A start takes a copy of it into the shifter, so software may stage the next byte while the current one is still on the wire.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the select output is high, the serial clock and data output are low, the idle flag reads 1 and the receive register reads 0x00.
- R2: A write to word address 0x80 stores bit 0 as the enable level. The select output equals its inverse and keeps that value across any number of transfers until 0x80 is written again.
- R3: A write to address 0x82 latches bits 7:0 as the transmit byte and does not start a transfer. If the write arrives while a byte is shifting, the in-flight byte is unchanged and the written byte is sent by the next start.
- R4: A write to address 0x81 (any data) while idle starts a transfer. The data output presents the latched byte most significant bit first and changes only when the serial clock falls (or at the start).
- R5: The serial clock idles low, each of its half periods lasts DIV_HALF system clocks, and a transfer produces exactly 8 rising edges.
- R6: The input line is sampled on each rising serial clock edge into the receive byte, most significant bit first. With the input tied to the inverse of the output, sending 0xA7 returns 0x58.
- R7: The idle flag (bit 0 of a read at 0x81) goes low in the cycle after a start is accepted and returns high 16*DIV_HALF cycles after that start, with the new receive byte already in place.
- R8: A write to 0x81 while a transfer is running is ignored: the transfer is neither restarted nor extended.
- R9: Reads return data one cycle after the request. 0x80 returns the enable level in bit 0, 0x81 returns the idle flag in bit 0, 0x82 returns the received byte in bits 7:0, and any other address returns 0. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The two functions that can meet in one cycle are a software write to the transmit-byte register and the last falling serial clock edge, which hands the received byte over and raises the idle flag. The bench times a write to 0x82 so that it reaches the bus in exactly the edge that completes a transfer. It then checks three things: the receive register holds the inverse of the old byte, the wire never showed the new byte, and the next start shifts the new byte out. A start written in mid-transfer meets the running shifter in the same way and is judged by the serial clock staying on its schedule.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int SPI_BYTE_W = 8;
    localparam int SPI_BIT_W  = $clog2(SPI_BYTE_W);

    // Register word addresses; software depends on these.
    localparam logic [7:0] REG_SELECT = 8'h80;
    localparam logic [7:0] REG_LAUNCH = 8'h81;
    localparam logic [7:0] REG_BYTE   = 8'h82;

    typedef struct packed {
        logic                  enable;
        logic                  idle;
        logic                  sck;
        logic [SPI_BYTE_W-1:0] hold;
        logic [SPI_BYTE_W-1:0] shift;
        logic [SPI_BYTE_W-1:0] capture;
        logic [SPI_BYTE_W-1:0] rx;
        logic [SPI_BIT_W-1:0]  bits;
    } engine_state_t;

endpackage

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (DIV_HALF <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counted
            localparam int CNT_W = $clog2(DIV_HALF);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (!run) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_byte_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_val,
    input  logic                  en_vld,
    input  logic [SPI_BYTE_W-1:0] tx_byte,
    input  logic                  tx_vld,
    input  logic                  start,
    input  logic                  tick,
    input  logic                  miso,
    output logic                  run,
    output logic                  ss_n,
    output logic                  sck,
    output logic                  mosi,
    output logic                  enable,
    output logic                  ready,
    output logic [SPI_BYTE_W-1:0] rx_byte
);

    localparam logic [SPI_BIT_W-1:0] LAST_BIT = SPI_BIT_W'(SPI_BYTE_W - 1);

    engine_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (en_vld) begin
            st_d.enable = en_val;
        end
        if (tx_vld) begin
            st_d.hold = tx_byte;
        end

        if (st_q.idle) begin
            if (start) begin
                st_d.idle  = 1'b0;
                st_d.sck   = 1'b0;
                st_d.shift = st_q.hold;
                st_d.bits  = '0;
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                // rising serial edge: sample input
                st_d.sck     = 1'b1;
                st_d.capture = {st_q.capture[SPI_BYTE_W-2:0], miso};
            end else begin
                // falling serial edge: advance output
                st_d.sck   = 1'b0;
                st_d.shift = {st_q.shift[SPI_BYTE_W-2:0], 1'b0};
                st_d.bits  = st_q.bits + 1'b1;
                if (st_q.bits == LAST_BIT) begin
                    st_d.idle = 1'b1;
                    st_d.rx   = st_q.capture;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.idle    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run     = !st_q.idle;
    assign ss_n    = !st_q.enable;
    assign sck     = st_q.sck;
    assign mosi    = st_q.shift[SPI_BYTE_W-1];
    assign enable  = st_q.enable;
    assign ready   = st_q.idle;
    assign rx_byte = st_q.rx;

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_cs,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  st_enable,
    input  logic                  st_ready,
    input  logic [SPI_BYTE_W-1:0] st_rx,
    output logic                  en_val,
    output logic                  en_vld,
    output logic                  start,
    output logic [SPI_BYTE_W-1:0] tx_byte,
    output logic                  tx_vld
);

    localparam logic [ADDR_W-1:0] A_SELECT = ADDR_W'(REG_SELECT);
    localparam logic [ADDR_W-1:0] A_LAUNCH = ADDR_W'(REG_LAUNCH);
    localparam logic [ADDR_W-1:0] A_BYTE   = ADDR_W'(REG_BYTE);

    logic                  wr, rd;
    logic [DATA_W-1:0]     rdata_d, rdata_q;

    assign wr = bus_cs && bus_we;
    assign rd = bus_cs && !bus_we;

    assign en_vld  = wr && (bus_addr == A_SELECT);
    assign en_val  = bus_wdata[0];
    assign start   = wr && (bus_addr == A_LAUNCH);
    assign tx_vld  = wr && (bus_addr == A_BYTE);
    assign tx_byte = bus_wdata[SPI_BYTE_W-1:0];

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            case (bus_addr)
                A_SELECT: rdata_d = DATA_W'(st_enable);
                A_LAUNCH: rdata_d = DATA_W'(st_ready);
                A_BYTE:   rdata_d = DATA_W'(st_rx);
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_ss_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic                  en_val, en_vld, start_pulse, tx_vld;
    logic [SPI_BYTE_W-1:0] tx_byte, rx_byte;
    logic                  enable_lvl, xfer_ready, run, tick;

    spi_reg_front #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .st_enable (enable_lvl),
        .st_ready  (xfer_ready),
        .st_rx     (rx_byte),
        .en_val    (en_val),
        .en_vld    (en_vld),
        .start     (start_pulse),
        .tx_byte   (tx_byte),
        .tx_vld    (tx_vld)
    );

    spi_sck_timer #(
        .DIV_HALF (DIV_HALF)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_shift_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_val  (en_val),
        .en_vld  (en_vld),
        .tx_byte (tx_byte),
        .tx_vld  (tx_vld),
        .start   (start_pulse),
        .tick    (tick),
        .miso    (spi_miso),
        .run     (run),
        .ss_n    (spi_ss_n),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .enable  (enable_lvl),
        .ready   (xfer_ready),
        .rx_byte (rx_byte)
    );

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_byte_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sck,
    input logic                  mosi,
    input logic                  ss_n,
    input logic                  ready,
    input logic [SPI_BYTE_W-1:0] rx_byte,
    input logic                  en_vld,
    input logic                  tx_vld,
    input logic                  start
);

    logic       sck_prev;
    logic [4:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sck_prev <= sck;
            if (ready && start) begin
                rise_cnt <= '0;
            end else if (sck && !sck_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R5: serial clock rests low whenever no transfer runs
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !sck);

    // R5: never more than eight rising edges in one transfer
    a_r5_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !sck_prev) |-> (rise_cnt < 5'(SPI_BYTE_W)));

    // R7: idle returns only after the eighth rising edge
    a_r7_done_after_eight: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (rise_cnt == 5'(SPI_BYTE_W)));

    // R4: output bit is settled when the clock rises
    a_r4_mosi_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    // R2: select moves only on a write to its register
    a_r2_select_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !en_vld |=> $stable(ss_n));

    // R3: loading a byte never starts a transfer
    a_r3_load_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && ready && !start) |=> ready);

    // R6: receive byte holds still while shifting
    a_r6_rx_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(rx_byte));

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .ss_n    (spi_ss_n),
    .ready   (xfer_ready),
    .rx_byte (rx_byte),
    .en_vld  (en_vld),
    .tx_vld  (tx_vld),
    .start   (start_pulse)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

    localparam int DIV  = 2;
    localparam int XFER = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_ss_n, spi_sck, spi_mosi, spi_miso;
    int          miso_mode = 0;   // 0 inverted loop, 1 low, 2 high, 3 direct loop

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;   // 4 time units: 250 MHz

    assign spi_miso = (miso_mode == 0) ? ~spi_mosi :
                      (miso_mode == 1) ? 1'b0 :
                      (miso_mode == 2) ? 1'b1 : spi_mosi;

    spi_byte_master #(.ADDR_W(8), .DATA_W(32), .DIV_HALF(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_ss_n  (spi_ss_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // Behavioural reference model, advanced on every rising clock.
    bit          m_live = 0;
    bit          m_en, m_busy;
    int          m_k;
    logic [7:0]  m_hold, m_cur, m_rx, m_exp;
    logic [31:0] m_rd;

    function automatic logic [7:0] expect_rx(int mode, logic [7:0] b);
        case (mode)
            0: return ~b;
            1: return 8'h00;
            2: return 8'hFF;
            default: return b;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_k = 0;
            m_hold = 0; m_cur = 0; m_rx = 0; m_exp = 0; m_rd = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            m_live = 1;
            if (bus_cs && !bus_we) begin
                case (bus_addr)
                    8'h80: m_rd = {31'b0, m_en};
                    8'h81: m_rd = {31'b0, !m_busy};
                    8'h82: m_rd = {24'b0, m_rx};
                    default: m_rd = 32'h0;
                endcase
            end
            if (m_busy) begin
                m_k++;
                if (m_k == XFER) begin
                    m_busy = 0;
                    m_rx = m_exp;
                end
            end
            if (bus_cs && bus_we) begin
                if (bus_addr == 8'h80) m_en = bus_wdata[0];
                if (bus_addr == 8'h81 && !was_busy) begin
                    m_busy = 1; m_k = 0; m_cur = m_hold;
                    m_exp = expect_rx(miso_mode, m_hold);
                end
                if (bus_addr == 8'h82) m_hold = bus_wdata[7:0];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_live && rst_n) begin
            logic e_sck, e_mosi;
            e_sck  = m_busy ? 1'((m_k / DIV) % 2) : 1'b0;
            e_mosi = (m_busy && m_k < XFER) ? m_cur[7 - m_k / (2 * DIV)] : 1'b0;
            chk("R2 ss_n", 32'(spi_ss_n), 32'(!m_en));
            chk("R5 sck", 32'(spi_sck), 32'(e_sck));
            chk("R4 mosi", 32'(spi_mosi), 32'(e_mosi));
            chk("R9 rdata", bus_rdata, m_rd);
        end
    end

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_we = 0;
    endtask

    task automatic bus_read(logic [7:0] a);
        @(negedge clk);
        bus_cs = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_cs = 0;
    endtask

    task automatic run_byte(logic [7:0] b, int mode, logic [7:0] exp_rx, string tag);
        miso_mode = mode;
        bus_write(8'h82, {24'b0, b});
        bus_write(8'h81, 32'h1);
        repeat (XFER + 2) @(negedge clk);
        bus_read(8'h82);
        chk(tag, bus_rdata, {24'b0, exp_rx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int j;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        chk("R1 ss_n", 32'(spi_ss_n), 32'h1);
        chk("R1 sck", 32'(spi_sck), 32'h0);
        chk("R1 mosi", 32'(spi_mosi), 32'h0);
        bus_read(8'h81);
        chk("R1 idle", bus_rdata, 32'h1);
        bus_read(8'h82);
        chk("R1 rx", bus_rdata, 32'h0);

        // R2: enable selects
        bus_write(8'h80, 32'h1);
        chk("R2 select low", 32'(spi_ss_n), 32'h0);
        bus_read(8'h80);
        chk("R9 read enable", bus_rdata, 32'h1);

        // R3: loading alone does not start
        miso_mode = 0;
        bus_write(8'h82, 32'hA7);
        repeat (4) @(negedge clk);
        chk("R3 no clock after load", 32'(spi_sck), 32'h0);
        bus_read(8'h81);
        chk("R3 still idle", bus_rdata, 32'h1);

        // R7: idle flag timing with continuous polling
        bus_write(8'h81, 32'h1);
        bus_cs = 1; bus_we = 0; bus_addr = 8'h81;
        j = 0;
        for (int n = 1; n <= XFER + 8; n++) begin
            @(negedge clk);
            if (bus_rdata[0] && j == 0) j = n;
        end
        bus_cs = 0;
        chk("R7 idle return cycle", 32'(j), 32'(XFER + 1));
        bus_read(8'h82);
        chk("R6 inverted A7", bus_rdata, 32'h58);

        // R6 with other input patterns; R2 select held throughout
        run_byte(8'h3C, 1, 8'h00, "R6 input low");
        run_byte(8'h5A, 2, 8'hFF, "R6 input high");
        chk("R2 select held", 32'(spi_ss_n), 32'h0);

        // R3 and R8: writes during a transfer
        miso_mode = 3;
        bus_write(8'h82, 32'hC3);
        bus_write(8'h81, 32'h1);
        repeat (6) @(negedge clk);
        bus_write(8'h82, 32'h99);
        bus_write(8'h81, 32'h1);
        repeat (XFER) @(negedge clk);
        bus_read(8'h82);
        chk("R3 in-flight byte kept", bus_rdata, 32'hC3);
        repeat (XFER) @(negedge clk);
        chk("R8 no restart", 32'(spi_sck), 32'h0);
        bus_read(8'h81);
        chk("R8 idle after ignored start", bus_rdata, 32'h1);
        bus_write(8'h81, 32'h1);
        repeat (XFER + 2) @(negedge clk);
        bus_read(8'h82);
        chk("R3 staged byte sent", bus_rdata, 32'h99);

        // Collision: byte write lands on the completing edge
        miso_mode = 0;
        bus_write(8'h82, 32'h0F);
        bus_write(8'h81, 32'h1);
        repeat (XFER - 2) @(negedge clk);
        bus_write(8'h82, 32'hF0);
        bus_read(8'h82);
        chk("R3 collision rx", bus_rdata, 32'hF0);
        bus_write(8'h81, 32'h1);
        repeat (XFER + 2) @(negedge clk);
        bus_read(8'h82);
        chk("R3 collision next byte", bus_rdata, 32'h0F);

        // R2: deselect; R9: unmapped accesses
        bus_write(8'h80, 32'h0);
        chk("R2 select high", 32'(spi_ss_n), 32'h1);
        bus_write(8'h83, 32'hFFFF_FFFF);
        bus_read(8'h83);
        chk("R9 unmapped read", bus_rdata, 32'h0);
        bus_write(8'h80, 32'h2);
        chk("R2 bit0 only", 32'(spi_ss_n), 32'h1);
        bus_read(8'h80);
        chk("R9 enable readback", bus_rdata, 32'h0);
        bus_read(8'h82);
        chk("R9 rx unchanged", bus_rdata, 32'h0F);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule